// File: doc/BRIEF.md
# Half-Lockable Cache Way Allocator

This block chooses which way of a set-associative cache receives a new line on a fill. Each cycle it looks at the valid bits of the indexed set and the state of a lock control, and it drives the index of the chosen way. If a candidate way is empty, the lowest-numbered one is chosen. If every candidate is full, a round-robin pointer supplies the victim. The pointer advances only when an allocate strobe is accepted and the choice came from the pointer.

When the lock control is high, only the upper half of the ways can be chosen, so the lower half stays resident. In this mode the victim comes from the upper bits of the same pointer, and the pointer steps by two, so the upper ways take turns. The lock can change at any cycle. Its effect on the chosen way is immediate, because the selection is combinational. The pointer itself is shared by both modes.

Top module: `way_victim_sel`

## Requirements
- R1: With lock_i low and at least one valid_i bit clear, way_o is the lowest index k with valid_i[k]==0. Bit k of valid_i belongs to way k, and way_o is a binary way index.
- R2: With lock_i low and all valid_i bits set, way_o equals the pointer. When alloc_i is high at a clock edge, the pointer increments by one modulo NUM_WAYS.
- R3: With lock_i high and at least one upper-half way invalid, way_o is the lowest invalid upper-half way. Empty lower-half ways have no effect on the choice.
- R4: With lock_i high and all upper-half ways valid, way_o is 2 when the pointer's top bit is 0 and 3 when it is 1 (four ways). An accepted alloc_i toggles the pointer's top bit and keeps its low bit.
- R5: While lock_i is high, way_o never selects way 0 or way 1, whatever valid_i holds.
- R6: Reset (rst_ni low) clears the pointer to 0, so the first normal-mode choice on a full set is way 0.
- R7: The pointer holds its value when alloc_i is low, and also when the allocation was served by an invalid way.
- R8: lock_i can change between any two cycles. way_o follows it in the same cycle, and both modes use the one shared pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_i | input | 1 | Allocate strobe; commits the current choice |
| lock_i | input | 1 | Restrict allocation to the upper half of the ways |
| valid_i | input | NUM_WAYS | Valid bits of the indexed set, bit k for way k |
| way_o | output | $clog2(NUM_WAYS) | Selected way index |

## Verification
The bench uses the default of four ways. At this size the pointer's top bit is the only bit the locked mode uses, and a step of two toggles exactly that bit. With four ways, every pointer value can be reached within a few allocations. This covers wraparound in both modes, mode switches part-way through a pointer sequence, and resets taken while the pointer is non-zero.

// File: rtl/way_victim_pkg.sv
package way_victim_pkg;
  localparam int unsigned DEF_WAYS = 4;

  function automatic int unsigned idx_w(input int unsigned ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction
endpackage

// File: rtl/way_first_free.sv
module way_first_free #(
  parameter int unsigned N = 4,
  localparam int unsigned W = way_victim_pkg::idx_w(N)
) (
  input  logic [N-1:0] cand_i,
  output logic         hit_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        hit_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end

  always_comb begin
    if (hit_o) a_r1_pick_is_cand: assert (cand_i[idx_o]);
  end
endmodule

// File: rtl/way_rr_ptr.sv
module way_rr_ptr #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] inc_i,
  output logic [W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (step_i) ptr_o <= ptr_o + inc_i;
  end

  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ptr_o == $past(ptr_o));
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel #(
  parameter int unsigned NUM_WAYS = way_victim_pkg::DEF_WAYS,
  localparam int unsigned WAY_W = way_victim_pkg::idx_w(NUM_WAYS),
  localparam int unsigned HALF  = NUM_WAYS / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  logic                lock_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  output logic [WAY_W-1:0]    way_o
);
  logic [NUM_WAYS-1:0] allow, cand;
  logic                hit;
  logic [WAY_W-1:0]    free_idx, ptr_q, rr_sel, inc;

  // locked mode masks off the lower half
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_mask
    if (g >= HALF) begin : g_up
      assign allow[g] = 1'b1;
    end else begin : g_lo
      assign allow[g] = ~lock_i;
    end
  end

  assign cand = ~valid_i & allow;

  way_first_free #(.N(NUM_WAYS)) u_free (
    .cand_i (cand),
    .hit_o  (hit),
    .idx_o  (free_idx)
  );

  // locked: upper pointer bits index the upper half, stepping by two
  assign rr_sel = lock_i ? {1'b1, ptr_q[WAY_W-1:1]} : ptr_q;
  assign inc    = lock_i ? WAY_W'(2) : WAY_W'(1);
  assign way_o  = hit ? free_idx : rr_sel;

  way_rr_ptr #(.W(WAY_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (alloc_i & ~hit),
    .inc_i  (inc),
    .ptr_o  (ptr_q)
  );

  a_r5_lower_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> way_o >= WAY_W'(HALF));

  a_r1_lowest_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && !(&valid_i)) |-> (!valid_i[way_o] &&
      ((way_o == '0) || ((valid_i & ((NUM_WAYS'(1) << way_o) - NUM_WAYS'(1))) ==
        ((NUM_WAYS'(1) << way_o) - NUM_WAYS'(1))))));

  a_r2_normal_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !lock_i && (&valid_i)) |=> ptr_q == $past(ptr_q) + WAY_W'(1));

  a_r4_locked_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && lock_i && (&valid_i[NUM_WAYS-1:HALF])) |=>
      (ptr_q[WAY_W-1] != $past(ptr_q[WAY_W-1])) && (ptr_q[0] == $past(ptr_q[0])));

  a_r7_free_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && (|(~valid_i & allow))) |=> $stable(ptr_q));
endmodule

// File: tb/way_victim_sel_bench.sv
module way_victim_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc = 1'b0;
  logic       lock = 1'b0;
  logic [3:0] valid = 4'h0;
  logic [1:0] way;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  way_victim_sel u_way_victim_sel (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .alloc_i (alloc),
    .lock_i  (lock),
    .valid_i (valid),
    .way_o   (way)
  );

  // {lock, alloc, valid[3:0], expected way[1:0]}
  localparam int NV = 15;
  localparam logic [7:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'b1111, 2'd0},  // R2 ptr 0->1
    {1'b0, 1'b1, 4'b1111, 2'd1},  // R2 ptr 1->2
    {1'b0, 1'b1, 4'b0110, 2'd0},  // R1 R7
    {1'b0, 1'b1, 4'b1011, 2'd2},  // R1
    {1'b0, 1'b1, 4'b0111, 2'd3},  // R1
    {1'b1, 1'b1, 4'b1111, 2'd3},  // R4 ptr 2->0
    {1'b1, 1'b1, 4'b1111, 2'd2},  // R4 ptr 0->2
    {1'b1, 1'b1, 4'b1100, 2'd3},  // R3 R5 ptr 2->0
    {1'b1, 1'b1, 4'b0011, 2'd2},  // R3
    {1'b1, 1'b1, 4'b0111, 2'd3},  // R3
    {1'b0, 1'b0, 4'b1111, 2'd0},  // R7 no strobe
    {1'b0, 1'b1, 4'b1111, 2'd0},  // R8 ptr 0->1
    {1'b1, 1'b1, 4'b1111, 2'd2},  // R8 R4 ptr 1->3
    {1'b0, 1'b1, 4'b1111, 2'd3},  // R8 ptr 3->0
    {1'b0, 1'b1, 4'b1111, 2'd0}   // R2 wrap
  };

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (way !== exp) begin
      errors++;
      $display("FAIL %s: way=%0d expected=%0d", req, way, exp);
    end
  endtask

  task automatic step(input logic l, input logic a, input logic [3:0] v,
                      input logic [1:0] exp, input string req);
    @(negedge clk);
    lock = l; alloc = a; valid = v;
    #1 check(req, exp);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: way=%0d expected=done", way);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    valid = 4'hF;
    repeat (2) @(negedge clk);
    #1 check("R6 reset", 2'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5:2], VEC[i][1:0], "R1-vec");
    end
    // ptr now 1: R8 same pointer read both ways
    step(1'b1, 1'b0, 4'b1111, 2'd2, "R8 locked view");
    step(1'b0, 1'b0, 4'b1111, 2'd1, "R8 normal view");
    // R5 lower ways empty must not be taken
    step(1'b1, 1'b0, 4'b1100, 2'd2, "R5 empty lower");
    // R7 fill from free way leaves ptr
    step(1'b0, 1'b1, 4'b1110, 2'd0, "R7 free fill");
    step(1'b0, 1'b0, 4'b1111, 2'd1, "R7 ptr kept");
    // R6 reset with ptr non-zero
    step(1'b0, 1'b1, 4'b1111, 2'd1, "R2 ptr 1->2");
    step(1'b0, 1'b0, 4'b1111, 2'd2, "R2 ptr is 2");
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R6 async reset", 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 4'b1111, 2'd2, "R6 locked after reset");
    @(negedge clk);
    alloc = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule